// File: doc/BRIEF.md
# Multi-core extended interrupt router

The block takes a set of level-sensitive interrupt inputs and sends each one to one of several CPU cores, and to one of four interrupt-pin lines on that core. Software sets the routing through a 32-bit register port. Each interrupt has a one-byte core selector. Each group of 32 interrupts shares a one-byte pin selector. A selector byte names its target by the position of its lowest set bit.

The block remembers the raw level of every input. It also keeps a separate in-service status word set for every core, and software clears those bits by writing 1. Delivery follows the current state of the registers:
- Turning an enable bit on delivers an interrupt that is already pending.
- Turning an enable bit off withdraws it.
- Moving an interrupt to another core withdraws it from the old core and raises it on the new one.

Two arrays, the node-type words and the bounce words, are only stored and read back. Reads have one cycle of latency. The status-word region is indexed by the core ID that comes with each access.

Top module: `eir_router`

## Requirements
- R1: After reset, every register array is zero, every pin output is low and every mapped read returns zero.
- R2: A selector byte decodes to the index of its lowest set bit. A zero byte, or an index of 4 or more (or at least the core count, for core selectors), decodes to 0. Core selector of IRQ i is byte i mod 4 (little-endian) of the word at 0x800 + 4*(i/4). Pin selector of group g = i/32 is byte g mod 4 of the word at 0x100 + 4*(g/4).
- R3: A rising input whose enable bit is set marks the IRQ in service on its target core. The output at index core*4+pin goes high after the first clock edge that samples the high level.
- R4: A rising input whose enable bit is clear changes no status bit and no pin output.
- R5: A falling input clears that IRQ's status bit and withdraws it from its pin line.
- R6: Output core*4+p is high exactly when some status bit of that core is set for an IRQ whose group selects pin p.
- R7: Enable word w sits at 0x200 + 4*w and covers IRQs 32w..32w+31 (bit = irq mod 32). Writing it delivers every IRQ whose enable bit goes from 0 to 1 while its input is high. It withdraws every IRQ whose enable bit goes from 1 to 0.
- R8: Status word w sits at 0x400 + 4*w, with the same bit layout. Reads and writes reach the copy of the core named on the requester-core input. Writing 1 to a bit clears it and withdraws that IRQ from its pin line.
- R9: A core-selector write that changes the target of an IRQ clears its old status bit. On the new core, the bit is set if the input is high and enabled. A write that leaves the target unchanged has no effect on status or pins.
- R10: Node-type words at 0x000..0x00C and bounce words at 0x300 + 4*w are stored and read back with no effect on routing.
- R11: Read data appears in the cycle after the read strobe. Offsets outside the mapped regions, and offsets at or above 0x900, read as zero, and writes to them change nothing.
- R12: An IRQ is in service on at most one core at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_IRQ | Level interrupt inputs |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 16 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_core | input | CW | Requester core ID, selects the status-word copy |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| pin_out | output | NUM_CORE*4 | Level per (core, pin), index core*4+pin |

## Verification
The bench builds the router with 64 IRQs and 4 cores. This gives two pin groups, so the group-level pin selector is exercised, including the fallback of an out-of-range byte to pin 0. Four cores let migration run between cores 3, 1 and 0, and let the requester-core input show that each core sees only its own status copy. IRQ 40 sits in the second enable and status word, which checks the word indexing beyond word 0.

// File: rtl/eir_pkg.sv
package eir_pkg;

    localparam int PINS       = 4;
    localparam int NODE_WORDS = 4;
    localparam int OFF_PMAP   = 'h100;
    localparam int OFF_EN     = 'h200;
    localparam int OFF_BNC    = 'h300;
    localparam int OFF_STAT   = 'h400;
    localparam int OFF_CMAP   = 'h800;
    localparam int WIN_END    = 'h900;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_NODE,
        SEL_PMAP,
        SEL_EN,
        SEL_BNC,
        SEL_STAT,
        SEL_CMAP
    } reg_sel_e;

    // Lowest set bit position; empty byte or out-of-range index gives 0.
    function automatic int unsigned low_index(input logic [7:0] b, input int unsigned limit);
        int unsigned r;
        r = 0;
        for (int k = 7; k >= 0; k--) begin
            if (b[k]) r = k;
        end
        if (r >= limit) r = 0;
        return r;
    endfunction

endpackage

// File: rtl/eir_byte_decode.sv
module eir_byte_decode #(
    parameter int COUNT = 4,
    parameter int LIMIT = 4,
    parameter int IW    = 2
) (
    input  logic [COUNT-1:0][7:0]    map_bytes,
    output logic [COUNT-1:0][IW-1:0] target
);
    for (genvar g = 0; g < COUNT; g++) begin : g_dec
        assign target[g] = IW'(eir_pkg::low_index(map_bytes[g], LIMIT));
    end
endmodule

// File: rtl/eir_pin_merge.sv
module eir_pin_merge #(
    parameter int NUM_IRQ = 64
) (
    input  logic [NUM_IRQ-1:0]      status,
    input  logic [NUM_IRQ-1:0][1:0] pin_sel,
    output logic [3:0]              lines
);
    always_comb begin
        lines = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            lines[pin_sel[i]] = lines[pin_sel[i]] | status[i];
        end
    end
endmodule

// File: rtl/eir_router.sv
module eir_router #(
    parameter int NUM_IRQ  = 64,
    parameter int NUM_CORE = 4,
    localparam int CW = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_IRQ-1:0]      irq_in,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [15:0]             bus_addr,
    input  logic [31:0]             bus_wdata,
    input  logic [CW-1:0]           bus_core,
    output logic [31:0]             bus_rdata,
    output logic [NUM_CORE*4-1:0]   pin_out
);
    import eir_pkg::*;

    localparam int NGRP = NUM_IRQ / 32;
    localparam int PMW  = (NGRP + 3) / 4;
    localparam int CMW  = NUM_IRQ / 4;

    logic [NUM_IRQ-1:0]               raw_q, en_q, en_n, clr_mask;
    logic [NUM_CORE-1:0][NUM_IRQ-1:0] isr_q, isr_n;
    logic [NUM_IRQ-1:0][7:0]          cmap_q, cmap_n;
    logic [PMW*4-1:0][7:0]            pmap_q, pmap_n;
    logic [NODE_WORDS-1:0][31:0]      node_q, node_n;
    logic [NGRP-1:0][31:0]            bnc_q, bnc_n;
    logic [31:0]                      rdata_q, rd_word;
    logic [NUM_IRQ-1:0][CW-1:0]       core_old, core_new;
    logic [NGRP-1:0][1:0]             pin_grp;
    logic [NUM_IRQ-1:0][1:0]          pin_sel;
    reg_sel_e                         sel;
    int                               off_w, widx;
    logic                             core_ok;

    // ---- address decode ----
    always_comb begin
        off_w   = int'({bus_addr[15:2], 2'b00});
        core_ok = int'(bus_core) < NUM_CORE;
        sel     = SEL_NONE;
        widx    = 0;
        if (off_w < 4*NODE_WORDS) begin
            sel = SEL_NODE; widx = off_w / 4;
        end else if (off_w >= OFF_PMAP && off_w < OFF_PMAP + 4*PMW) begin
            sel = SEL_PMAP; widx = (off_w - OFF_PMAP) / 4;
        end else if (off_w >= OFF_EN && off_w < OFF_EN + 4*NGRP) begin
            sel = SEL_EN; widx = (off_w - OFF_EN) / 4;
        end else if (off_w >= OFF_BNC && off_w < OFF_BNC + 4*NGRP) begin
            sel = SEL_BNC; widx = (off_w - OFF_BNC) / 4;
        end else if (off_w >= OFF_STAT && off_w < OFF_STAT + 4*NGRP) begin
            sel = SEL_STAT; widx = (off_w - OFF_STAT) / 4;
        end else if (off_w >= OFF_CMAP && off_w < OFF_CMAP + 4*CMW && off_w < WIN_END) begin
            sel = SEL_CMAP; widx = (off_w - OFF_CMAP) / 4;
        end
    end

    // ---- register writes ----
    always_comb begin
        en_n     = en_q;
        cmap_n   = cmap_q;
        pmap_n   = pmap_q;
        node_n   = node_q;
        bnc_n    = bnc_q;
        clr_mask = '0;
        if (bus_wr) begin
            unique case (sel)
                SEL_NODE: node_n[widx] = bus_wdata;
                SEL_PMAP: for (int b = 0; b < 4; b++) pmap_n[widx*4+b] = bus_wdata[8*b +: 8];
                SEL_EN:   en_n[widx*32 +: 32] = bus_wdata;
                SEL_BNC:  bnc_n[widx] = bus_wdata;
                SEL_STAT: if (core_ok) clr_mask[widx*32 +: 32] = bus_wdata;
                SEL_CMAP: for (int b = 0; b < 4; b++) cmap_n[widx*4+b] = bus_wdata[8*b +: 8];
                default:  ;
            endcase
        end
    end

    // ---- routing decode ----
    eir_byte_decode #(.COUNT(NUM_IRQ), .LIMIT(NUM_CORE), .IW(CW)) u_core_old (
        .map_bytes(cmap_q), .target(core_old));
    eir_byte_decode #(.COUNT(NUM_IRQ), .LIMIT(NUM_CORE), .IW(CW)) u_core_new (
        .map_bytes(cmap_n), .target(core_new));
    eir_byte_decode #(.COUNT(NGRP), .LIMIT(PINS), .IW(2)) u_pin (
        .map_bytes(pmap_q[NGRP-1:0]), .target(pin_grp));

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_pinsel
        assign pin_sel[i] = pin_grp[i/32];
    end

    // ---- in-service update: withdraw wins over deliver ----
    always_comb begin
        for (int i = 0; i < NUM_IRQ; i++) begin
            logic val;
            val = isr_q[core_old[i]][i];
            if (core_old[i] != core_new[i]) val = raw_q[i] & en_q[i];
            if (clr_mask[i] && bus_core == core_old[i]) val = 1'b0;
            if ((irq_in[i] & ~raw_q[i] & en_n[i]) | (en_n[i] & ~en_q[i] & raw_q[i])) val = 1'b1;
            if ((~irq_in[i] & raw_q[i]) | (~en_n[i] & en_q[i])) val = 1'b0;
            for (int c = 0; c < NUM_CORE; c++) begin
                isr_n[c][i] = (int'(core_new[i]) == c) & val;
            end
        end
    end

    // ---- read mux ----
    always_comb begin
        rd_word = '0;
        unique case (sel)
            SEL_NODE: rd_word = node_q[widx];
            SEL_PMAP: rd_word = {pmap_q[widx*4+3], pmap_q[widx*4+2], pmap_q[widx*4+1], pmap_q[widx*4]};
            SEL_EN:   rd_word = en_q[widx*32 +: 32];
            SEL_BNC:  rd_word = bnc_q[widx];
            SEL_STAT: if (core_ok) rd_word = isr_q[bus_core][widx*32 +: 32];
            SEL_CMAP: rd_word = {cmap_q[widx*4+3], cmap_q[widx*4+2], cmap_q[widx*4+1], cmap_q[widx*4]};
            default:  rd_word = '0;
        endcase
    end

    // ---- state register ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q   <= '0;
            en_q    <= '0;
            isr_q   <= '0;
            cmap_q  <= '0;
            pmap_q  <= '0;
            node_q  <= '0;
            bnc_q   <= '0;
            rdata_q <= '0;
        end else begin
            raw_q  <= irq_in;
            en_q   <= en_n;
            isr_q  <= isr_n;
            cmap_q <= cmap_n;
            pmap_q <= pmap_n;
            node_q <= node_n;
            bnc_q  <= bnc_n;
            if (bus_rd) rdata_q <= rd_word;
        end
    end

    // ---- outputs ----
    assign bus_rdata = rdata_q;
    for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
        eir_pin_merge #(.NUM_IRQ(NUM_IRQ)) u_merge (
            .status(isr_q[c]), .pin_sel(pin_sel), .lines(pin_out[c*4 +: 4]));
    end

endmodule

// File: rtl/eir_router_chk.sv
module eir_router_chk #(
    parameter int NUM_IRQ  = 64,
    parameter int NUM_CORE = 4
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [NUM_IRQ-1:0]               irq_in,
    input logic [NUM_IRQ-1:0]               raw_q,
    input logic [NUM_IRQ-1:0]               en_q,
    input logic [NUM_CORE-1:0][NUM_IRQ-1:0] isr_q,
    input logic                             bus_rd,
    input logic [15:0]                      bus_addr,
    input logic [31:0]                      bus_rdata,
    input logic [NUM_CORE*4-1:0]            pin_out
);
    logic armed = 1'b0;
    logic [NUM_IRQ-1:0] isr_any;

    always_ff @(posedge clk) armed <= rst_n;

    always_comb begin
        isr_any = '0;
        for (int c = 0; c < NUM_CORE; c++) isr_any = isr_any | isr_q[c];
    end

    AST_STATUS_NEEDS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_any & ~(raw_q & en_q)) == '0); // R5

    AST_RAW_TRACKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> raw_q == $past(irq_in)); // R4

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr >= 16'h0900) |=> bus_rdata == 32'h0); // R11

    for (genvar c = 0; c < NUM_CORE; c++) begin : g_pin
        AST_PIN_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
            (|pin_out[c*4 +: 4]) |-> (|isr_q[c])); // R6
    end

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_col
        logic [NUM_CORE-1:0] col;
        always_comb begin
            for (int c = 0; c < NUM_CORE; c++) col[c] = isr_q[c][i];
        end
        AST_SINGLE_CORE: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(col) <= 1); // R12
    end
endmodule

bind eir_router eir_router_chk #(.NUM_IRQ(NUM_IRQ), .NUM_CORE(NUM_CORE)) u_chk (.*);

// File: tb/test_eir_router.sv
module test_eir_router;
    localparam int NI = 64;
    localparam int NC = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NI-1:0]  irq_in = '0;
    logic           bus_wr = 1'b0;
    logic           bus_rd = 1'b0;
    logic [15:0]    bus_addr = '0;
    logic [31:0]    bus_wdata = '0;
    logic [1:0]     bus_core = '0;
    logic [31:0]    bus_rdata;
    logic [NC*4-1:0] pin_out;

    int errs = 0;
    int checks = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    eir_router #(.NUM_IRQ(NI), .NUM_CORE(NC)) i_eir_router (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_core(bus_core),
        .bus_rdata(bus_rdata), .pin_out(pin_out));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic [1:0] c);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_core = c;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [1:0] c, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a; bus_core = c;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic drive(input int i, input logic v);
        @(negedge clk);
        irq_in[i] = v;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 pins", 32'(pin_out), 32'h0);
        rd(16'h0200, 2'd0, d); chk("R1 enable", d, 32'h0);
        rd(16'h0800, 2'd0, d); chk("R1 core map", d, 32'h0);
    endtask

    task automatic t_route();
        logic [31:0] d;
        wr(16'h0100, 32'h0000_3004, 2'd0);   // group0 -> pin2, group1 0x30 -> pin0
        wr(16'h0804, 32'h0000_0800, 2'd0);   // irq5 -> core3
        wr(16'h0200, 32'h0000_0020, 2'd0);
        drive(5, 1'b1);
        chk("R3 pin core3/pin2", 32'(pin_out), 32'h4000);
        rd(16'h0400, 2'd3, d); chk("R8 status core3", d, 32'h20);
        rd(16'h0400, 2'd0, d); chk("R8 status core0", d, 32'h0);
        rd(16'h0100, 2'd0, d); chk("R2 pin map readback", d, 32'h3004);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        drive(7, 1'b1);
        chk("R4 disabled rise", 32'(pin_out), 32'h4000);
        rd(16'h0400, 2'd0, d); chk("R4 status", d, 32'h0);
        wr(16'h0200, 32'h0000_00A0, 2'd0);
        chk("R7 enable rise", 32'(pin_out), 32'h4004);
        rd(16'h0400, 2'd0, d); chk("R7 status", d, 32'h80);
        wr(16'h0200, 32'h0000_0020, 2'd0);
        chk("R7 enable fall", 32'(pin_out), 32'h4000);
    endtask

    task automatic t_fall_w1c();
        logic [31:0] d;
        drive(5, 1'b0);
        chk("R5 fall", 32'(pin_out), 32'h0);
        rd(16'h0400, 2'd3, d); chk("R5 status", d, 32'h0);
        drive(5, 1'b1);
        chk("R3 re-raise", 32'(pin_out), 32'h4000);
        wr(16'h0400, 32'h0000_00A0, 2'd3);
        chk("R8 w1c pin", 32'(pin_out), 32'h0);
        rd(16'h0400, 2'd3, d); chk("R8 w1c status", d, 32'h0);
    endtask

    task automatic t_migrate();
        logic [31:0] d;
        wr(16'h0804, 32'h0000_0200, 2'd0);   // irq5 -> core1
        chk("R9 move pin", 32'(pin_out), 32'h0040);
        rd(16'h0400, 2'd1, d); chk("R9 new core", d, 32'h20);
        rd(16'h0400, 2'd3, d); chk("R12 old core clear", d, 32'h0);
        wr(16'h0400, 32'h0000_0020, 2'd1);
        wr(16'h0804, 32'h0000_0200, 2'd0);   // same target
        chk("R9 unchanged target", 32'(pin_out), 32'h0);
        wr(16'h0804, 32'h0000_1000, 2'd0);   // bit4 -> falls back to core0
        chk("R2 core fallback", 32'(pin_out), 32'h0004);
        rd(16'h0400, 2'd1, d); chk("R12 core1 clear", d, 32'h0);
    endtask

    task automatic t_merge();
        logic [31:0] d;
        wr(16'h0200, 32'h0000_00A0, 2'd0);
        drive(5, 1'b0);
        chk("R6 pin held by irq7", 32'(pin_out), 32'h0004);
        rd(16'h0400, 2'd0, d); chk("R6 status", d, 32'h80);
        wr(16'h0204, 32'h0000_0100, 2'd0);
        drive(40, 1'b1);
        chk("R2 pin fallback group1", 32'(pin_out), 32'h0005);
        rd(16'h0404, 2'd0, d); chk("R8 word1 core0", d, 32'h100);
        rd(16'h0404, 2'd2, d); chk("R8 word1 core2", d, 32'h0);
    endtask

    task automatic t_store_unmapped();
        logic [31:0] d;
        wr(16'h0008, 32'hDEAD_BEEF, 2'd0);
        wr(16'h0304, 32'h1234_5678, 2'd0);
        rd(16'h0008, 2'd0, d); chk("R10 node word", d, 32'hDEAD_BEEF);
        rd(16'h0304, 2'd0, d); chk("R10 bounce word", d, 32'h1234_5678);
        chk("R10 no routing effect", 32'(pin_out), 32'h0005);
        wr(16'h00F0, 32'hFFFF_FFFF, 2'd0);
        wr(16'h0900, 32'hFFFF_FFFF, 2'd0);
        rd(16'h00F0, 2'd0, d); chk("R11 gap read", d, 32'h0);
        rd(16'h0900, 2'd0, d); chk("R11 window end", d, 32'h0);
        rd(16'h0008, 2'd0, d); chk("R11 node intact", d, 32'hDEAD_BEEF);
        chk("R11 pins intact", 32'(pin_out), 32'h0005);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_route();
        t_enable();
        t_fall_w1c();
        t_migrate();
        t_merge();
        t_store_unmapped();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            errs++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule